// File: doc/BRIEF.md
# NAND Ready/Busy Event Monitor

This block watches the ready/busy outputs of up to four NAND devices and turns them into register-visible state and one interrupt. Each line is brought into the clock domain by a short flop chain. Its synchronized level is shown in a status word, where 1 means ready. One line, chosen by a control bit, feeds a detector. The detector raises a sticky flag when that line goes from busy to ready.

Two more sticky flags record single-cycle completion pulses from a command sequencer: one for command done and one for DMA done. Software clears any flag by writing 1 to its bit. An enable word with the same bit layout masks the flags into a single level-sensitive interrupt output.

The register port is a plain write strobe with an address and data, plus a read-data output. The read data is a combinational function of the address.

Top module: `rb_event_monitor`

## Requirements
- R1: Status word (address 1) bits 8 to 11 show the synchronized level of lines 0 to 3, with 1 meaning ready. A pin change first shows in the status word after the second rising clock edge that samples it.
- R2: Status bit 0 is set when the selected line goes from busy to ready. It is set on the third edge after the pin rises, and it stays set until cleared. Control word (address 0) bit 3 picks the line: 0 selects line 0, and 1 selects line 1.
- R3: Changing the selection, or a busy-to-ready change on a line that is not selected, never sets status bit 0.
- R4: A one-cycle pulse on cmd_done_i sets status bit 1, and a pulse on dma_done_i sets status bit 2. The flag is visible right after the edge that samples the pulse.
- R5: A write to the status word clears each flag whose data bit is 1. Flags whose data bit is 0 are left as they are. The level bits cannot be written.
- R6: When a set event and a write-one clear hit the same flag in the same cycle, the flag ends up set.
- R7: Enable word (address 2) bits 0 to 2 match the flag positions. irq_o is high exactly when some flag and its enable bit are both 1.
- R8: Reset (synchronous, active low) clears all flags, the enables and the select bit, so irq_o is low. It also presets the synchronizers to ready, so pins held ready through reset raise no event.
- R9: Reads of the control word return only bit 3, reads of the enable word return only bits 0 to 2, and address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rb_pin_i | input | NUM_LINES | Raw ready/busy lines, 1 = ready |
| cmd_done_i | input | 1 | One-cycle command-complete pulse |
| dma_done_i | input | 1 | One-cycle DMA-complete pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address: 0 control, 1 status, 2 enable |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i |
| irq_o | output | 1 | Level interrupt: any enabled flag set |

## Verification
- A pin change reaches the status level bits after two edges and the ready flag after three.
- Pulses and register writes take effect on the next edge.
- irq_o and read data follow the state combinationally, in the same cycle.
- The bench holds every stimulus for an exact number of edges before queueing an expectation. The monitor compares each expectation on the falling edge of that same cycle, so an early or a late result both miscompare.

// File: rtl/rbmon_pkg.sv
// Shared constants for the ready/busy event monitor: register addresses
// and bit positions that software and the bench both rely on.
package rbmon_pkg;
    localparam int FLAG_CNT  = 3;   // sticky flags in status/enable words
    localparam int FLAG_RDY  = 0;   // selected line went busy -> ready
    localparam int FLAG_CMD  = 1;   // command done
    localparam int FLAG_DMA  = 2;   // DMA done
    localparam int SEL_BIT   = 3;   // control bit choosing the watched line
    localparam int LEVEL_LSB = 8;   // first live-level bit in status word

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_IEN  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/rbmon_sync.sv
// Multi-flop synchronizer for one asynchronous ready/busy line.
// Assumes the input is a slow level; resets to "ready" (1) so that
// an idle line produces no edge when reset is released.
module rbmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rbmon_rise.sv
// Per-line busy-to-ready detector. Keeps the previous synchronized level
// of every line, so switching the selection never fabricates an edge.
// Assumes inputs are already synchronous.
module rbmon_rise #(
    parameter int LINES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lvl_i,
    output logic [LINES-1:0] rise_o
);
    logic [LINES-1:0] prev_q;

    // Remember last cycle's levels; reset matches the synchronizer preset.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/rbmon_flag.sv
// One sticky event flag with write-one-to-clear. A set in the same cycle
// as a clear wins. Assumes set and clear are synchronous single-cycle.
module rbmon_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Hold, clear or set the flag; set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/rb_event_monitor.sv
// Ready/busy event monitor: synchronizes NAND ready/busy lines, reports
// their levels, latches a busy-to-ready event on the selected line and
// two sequencer completion events, and masks them into one interrupt.
// Assumes NUM_LINES >= 2 (select bit chooses line 0 or 1) and that
// LEVEL_LSB + NUM_LINES fits in DATA_W.
module rb_event_monitor #(
    parameter int NUM_LINES   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2,
    parameter int DATA_W      = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] rb_pin_i,
    input  logic                 cmd_done_i,
    input  logic                 dma_done_i,
    input  logic                 reg_wr_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    output logic                 irq_o
);
    import rbmon_pkg::*;

    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [NUM_LINES-1:0] lvl;
    logic [NUM_LINES-1:0] rise;
    logic [FLAG_CNT-1:0]  flag_q;
    logic [FLAG_CNT-1:0]  flag_set;
    logic [FLAG_CNT-1:0]  flag_clr;
    logic [FLAG_CNT-1:0]  ien_q;
    logic                 sel_q;
    logic [IDX_W-1:0]     sel_idx;
    reg_sel_e             reg_sel;
    logic                 wr_stat;
    logic                 unused_wdata;

    assign reg_sel      = reg_sel_e'(reg_addr_i[1:0]);
    assign wr_stat      = reg_wr_i && (reg_sel == REG_STAT);
    assign sel_idx      = IDX_W'(sel_q);
    assign unused_wdata = ^reg_wdata_i;

    // One synchronizer per ready/busy line.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
        rbmon_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  (rb_pin_i[g]),
            .q_o  (lvl[g])
        );
    end

    rbmon_rise #(.LINES(NUM_LINES)) i_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (lvl),
        .rise_o(rise)
    );

    // Event sources in flag-bit order.
    always_comb begin
        flag_set           = '0;
        flag_set[FLAG_RDY] = rise[sel_idx];
        flag_set[FLAG_CMD] = cmd_done_i;
        flag_set[FLAG_DMA] = dma_done_i;
    end

    assign flag_clr = wr_stat ? reg_wdata_i[FLAG_CNT-1:0] : '0;

    // One sticky flag per event.
    for (genvar f = 0; f < FLAG_CNT; f++) begin : g_flag
        rbmon_flag i_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(flag_set[f]),
            .clr_i(flag_clr[f]),
            .q_o  (flag_q[f])
        );
    end

    // Control and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            ien_q <= '0;
        end else if (reg_wr_i) begin
            if (reg_sel == REG_CTRL) sel_q <= reg_wdata_i[SEL_BIT];
            if (reg_sel == REG_IEN)  ien_q <= reg_wdata_i[FLAG_CNT-1:0];
        end
    end

    // Read-back multiplexer.
    always_comb begin
        reg_rdata_o = '0;
        case (reg_sel)
            REG_CTRL: reg_rdata_o[SEL_BIT] = sel_q;
            REG_STAT: begin
                reg_rdata_o[FLAG_CNT-1:0]           = flag_q;
                reg_rdata_o[LEVEL_LSB +: NUM_LINES] = lvl;
            end
            REG_IEN:  reg_rdata_o[FLAG_CNT-1:0] = ien_q;
            default:  reg_rdata_o = '0;
        endcase
    end

    assign irq_o = |(flag_q & ien_q);
endmodule

// File: rtl/rbmon_chk.sv
// Checker for rb_event_monitor: temporal properties on flags, enables
// and the interrupt. Attached with the bind at the end of this file.
module rbmon_chk #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              cmd_pulse,
    input logic              dma_pulse,
    input logic [2:0]        flags,
    input logic [2:0]        ien,
    input logic              irq
);
    logic wr_stat;
    assign wr_stat = reg_wr && (reg_addr == ADDR_W'(1));

    // R2: ready flag is sticky unless cleared by a write of one.
    a_r2_rdy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !(wr_stat && reg_wdata[0])) |=> flags[0]);

    // R4: a command pulse sets its flag.
    a_r4_cmd_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pulse |=> flags[1]);

    // R5: write-one clears the command flag when no pulse competes.
    a_r5_w1c_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[1] && !cmd_pulse) |=> !flags[1]);

    // R5: writing zero leaves the DMA flag alone.
    a_r5_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[2] && wr_stat && !reg_wdata[2]) |=> flags[2]);

    // R6: a DMA pulse wins over a simultaneous clear.
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_pulse && wr_stat && reg_wdata[2]) |=> flags[2]);

    // R7: an interrupt needs a set flag and an enable.
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flags != 3'b000) && (ien != 3'b000)));

    // R8: leaving reset, everything is clear and the interrupt is low.
    a_r8_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flags == 3'b000 && ien == 3'b000 && !irq));
endmodule

bind rb_event_monitor rbmon_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr_i),
    .reg_addr (reg_addr_i),
    .reg_wdata(reg_wdata_i),
    .cmd_pulse(cmd_done_i),
    .dma_pulse(dma_done_i),
    .flags    (flag_q),
    .ien      (ien_q),
    .irq      (irq_o)
);

// File: tb/test_rb_event_monitor.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected read data and interrupt
// level; a falling-edge monitor pops and compares against the ports.
module test_rb_event_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rb_pin = 4'hF;
    logic        cmd_done = 1'b0;
    logic        dma_done = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    typedef struct {
        logic [31:0] rdata;
        logic        irq;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    rb_event_monitor i_rb_event_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .rb_pin_i   (rb_pin),
        .cmd_done_i (cmd_done),
        .dma_done_i (dma_done),
        .reg_wr_i   (reg_wr),
        .reg_addr_i (reg_addr),
        .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .irq_o      (irq)
    );

    // Monitor: compare queued expectations in the middle of the cycle.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (reg_rdata !== it.rdata || irq !== it.irq) begin
                n_fails++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         it.tag, reg_rdata, irq, it.rdata, it.irq);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [31:0] v,
                              input logic ir, input string tag);
        item_t it;
        reg_addr = a;
        it.rdata = v;
        it.irq   = ir;
        it.tag   = tag;
        sb_q.push_back(it);
        tick();
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    function automatic logic [31:0] st(input logic [3:0] lv, input logic [2:0] f);
        return {20'd0, lv, 5'd0, f};
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R8: reset state
        expect_reg(2'd0, 32'h0, 1'b0, "R8 ctrl after reset");
        expect_reg(2'd1, st(4'hF, 3'b000), 1'b0, "R8 status after reset");
        expect_reg(2'd2, 32'h0, 1'b0, "R8 enable after reset");
        // R9: unused address
        expect_reg(2'd3, 32'h0, 1'b0, "R9 address 3 reads zero");
        // R1: levels after two edges; a busy transition sets nothing
        rb_pin = 4'b1010;
        tick();
        expect_reg(2'd1, st(4'hF, 3'b000), 1'b0, "R1 one edge: old level");
        expect_reg(2'd1, st(4'hA, 3'b000), 1'b0, "R1 two edges: new level");
        // R2: line 0 busy -> ready, flag on third edge
        rb_pin = 4'b1011;
        tick(); tick();
        expect_reg(2'd1, st(4'hB, 3'b000), 1'b0, "R2 level seen, flag not yet");
        expect_reg(2'd1, st(4'hB, 3'b001), 1'b0, "R2 flag set on line 0");
        expect_reg(2'd1, st(4'hB, 3'b001), 1'b0, "R2 flag sticky");
        // R5: zero keeps, one clears; level bits not writable
        wr(2'd1, 32'h0000_0F06);
        expect_reg(2'd1, st(4'hB, 3'b001), 1'b0, "R5 writing zero keeps flag");
        wr(2'd1, 32'h0000_0001);
        expect_reg(2'd1, st(4'hB, 3'b000), 1'b0, "R5 write one clears flag");
        // R3: rise on unselected line 1
        rb_pin = 4'b1001;
        repeat (3) tick();
        rb_pin = 4'b1011;
        repeat (4) tick();
        expect_reg(2'd1, st(4'hB, 3'b000), 1'b0, "R3 unselected line ignored");
        // R3: switch selection from busy line 0 to ready line 1
        rb_pin = 4'b1010;
        repeat (3) tick();
        wr(2'd0, 32'hFFFF_FFFF);
        expect_reg(2'd0, 32'h0000_0008, 1'b0, "R9 ctrl reads only bit 3");
        repeat (2) tick();
        expect_reg(2'd1, st(4'hA, 3'b000), 1'b0, "R3 selection change no event");
        // R2: line 1 selected, busy -> ready
        rb_pin = 4'b1000;
        repeat (3) tick();
        rb_pin = 4'b1010;
        tick(); tick();
        expect_reg(2'd1, st(4'hA, 3'b000), 1'b0, "R2 line 1 level seen");
        expect_reg(2'd1, st(4'hA, 3'b001), 1'b0, "R2 flag set on line 1");
        wr(2'd1, 32'h1);
        // R4: completion pulses
        cmd_done = 1'b1; tick(); cmd_done = 1'b0;
        expect_reg(2'd1, st(4'hA, 3'b010), 1'b0, "R4 cmd done flag");
        dma_done = 1'b1; tick(); dma_done = 1'b0;
        expect_reg(2'd1, st(4'hA, 3'b110), 1'b0, "R4 dma done flag");
        // R7: masking
        wr(2'd2, 32'hFFFF_FFFA);
        expect_reg(2'd2, 32'h0000_0002, 1'b1, "R7 enable cmd raises irq");
        wr(2'd1, 32'h2);
        expect_reg(2'd1, st(4'hA, 3'b100), 1'b0, "R7 dma flag masked, irq low");
        wr(2'd2, 32'h4);
        expect_reg(2'd1, st(4'hA, 3'b100), 1'b1, "R7 enable dma raises irq");
        // R6: set and clear in the same cycle
        cmd_done = 1'b1; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h2;
        tick();
        cmd_done = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        expect_reg(2'd1, st(4'hA, 3'b110), 1'b1, "R6 set wins over clear");
        wr(2'd1, 32'h6);
        expect_reg(2'd1, st(4'hA, 3'b000), 1'b0, "R5 both flags cleared");
        // R8: mid-run reset
        wr(2'd2, 32'h7);
        cmd_done = 1'b1; tick(); cmd_done = 1'b0;
        expect_reg(2'd1, st(4'hA, 3'b010), 1'b1, "R7 irq before reset");
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        expect_reg(2'd1, st(4'hF, 3'b000), 1'b0, "R8 flags cleared by reset");
        expect_reg(2'd2, 32'h0, 1'b0, "R8 enables cleared by reset");
        expect_reg(2'd0, 32'h0, 1'b0, "R8 select cleared by reset");
        tick();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule